// File: doc/BRIEF.md
# Fractional Clock Divider with Triggered Update

This block turns one of several incoming clock-enable streams into a slower clock-enable pulse stream. The divide ratio is a fixed-point quantity: software writes an integer field, and the block divides by that field plus one whole unit, where one unit is `2^FRAC_W` counts. A field of zero passes every input enable through. Any non-zero field gives a ratio between 1.0 and just under `2^(DIV_W-FRAC_W)+1`, in steps of `1/2^FRAC_W`. A fractional accumulator spreads the output pulses as evenly as the ratio permits.

Both the divisor field and the source-selector field are staged. A write to either has no effect on the output until software sets the trigger. The trigger then stays readable as busy until the staged pair has been copied into the working registers. The copy happens at the next output period boundary, which is the cycle in which the accumulator wraps. Output periods therefore never straddle two settings. The selector picks one enable stream by index. An index with no stream behind it keeps the output silent, and a trigger issued in that state completes on the next cycle.

Top module: `frac_clk_divider`

## Requirements
- R1: After reset, `trig_busy_o` and `div_pulse_o` are 0. The working divisor field is `RST_DIV` (default 0, a ratio of 1.0) and the working selector is `RST_SEL` (default 0). With these defaults, every enable on `src_en_i[0]` yields one output pulse.
- R2: The scaled divisor is the working field plus `2^FRAC_W`. Each selected enable adds `2^FRAC_W` to the accumulator, and a pulse is produced when the sum reaches the scaled divisor, which is then subtracted. Starting from an update, N selected enables therefore give exactly floor(N·2^FRAC_W / (field + 2^FRAC_W)) pulses.
- R3: `div_pulse_o` is high for exactly one cycle, on the cycle after the selected enable that completes a period. It is never high otherwise.
- R4: A write through `div_wr_i` or `sel_wr_i` does not change the output behaviour until a trigger completes. Staged values may be rewritten while an update is pending, and the last value written is the one applied.
- R5: A cycle with `trig_set_i` high sets `trig_busy_o` on the following cycle. It stays high until the update completes. A trigger that arrives while an update is already pending changes nothing.
- R6: While busy, the update is applied at the clock edge that produces an output pulse: `trig_busy_o` falls in the same cycle that `div_pulse_o` rises. The accumulator then restarts from zero under the new settings.
- R7: Selector value k (0 ≤ k < `NUM_SRC`) selects `src_en_i[k]`. A working selector value of `NUM_SRC` or above produces no pulses at all. A pending update made while in that state completes on the first clock edge after `trig_busy_o` rises.
- R8: Enable streams other than the selected one have no effect on the output.
- R9: The largest field value, `2^DIV_W-1`, gives a scaled divisor of `2^DIV_W-1+2^FRAC_W`. With the defaults this is 263, so 263 enables give 8 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en_i | input | NUM_SRC | Candidate input enable streams, one bit per source |
| div_wr_i | input | 1 | Write strobe for the staged divisor field |
| div_wdata_i | input | DIV_W | Divisor field value (scaled divisor minus 2^FRAC_W) |
| sel_wr_i | input | 1 | Write strobe for the staged selector field |
| sel_wdata_i | input | SEL_W | Selector field value (source index) |
| trig_set_i | input | 1 | Writes 1 to the self-clearing update trigger |
| trig_busy_o | output | 1 | Trigger readback: 1 while an update is pending |
| div_pulse_o | output | 1 | Divided clock-enable pulse |

## Verification
An output pulse is due on the edge after the selected enable that completes a period, so it is seen one falling edge after that enable is driven. Busy is due one edge after the trigger and drops at the commit edge, together with the pulse.

The bench drives inputs on the falling edge and compares both outputs on the next falling edge against a requirement-level model of the accumulator, the staging and the trigger. Pulse-count windows always begin right after a completed update, so the closed-form count of R2 applies. Each window ends with one idle cycle, so that the last pulse is collected.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    // State of the self-clearing update request
    typedef enum logic {
        TRIG_IDLE = 1'b0,
        TRIG_WAIT = 1'b1
    } trig_state_e;

    // Accumulator width able to hold (scaled divisor - 1) + one step
    function automatic int unsigned acc_width(int unsigned div_w, int unsigned frac_w);
        return ((div_w > frac_w) ? div_w : frac_w) + 2;
    endfunction

    // Selector width for a given number of sources (at least one bit)
    function automatic int unsigned sel_width(int unsigned n_src);
        return (n_src > 1) ? $clog2(n_src) : 1;
    endfunction

endpackage

// File: rtl/frac_div_cfg.sv
module frac_div_cfg
    import frac_div_pkg::*;
#(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned RST_DIV = 0,
    parameter int unsigned RST_SEL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr_i,
    input  logic [DIV_W-1:0] div_wdata_i,
    input  logic             sel_wr_i,
    input  logic [SEL_W-1:0] sel_wdata_i,
    input  logic             trig_set_i,
    input  logic             boundary_i,
    output logic [DIV_W-1:0] act_div_o,
    output logic [SEL_W-1:0] act_sel_o,
    output logic             busy_o,
    output logic             commit_o
);

    trig_state_e      state_q;
    logic [DIV_W-1:0] stg_div_q;
    logic [SEL_W-1:0] stg_sel_q;

    assign commit_o = (state_q == TRIG_WAIT) && boundary_i;
    assign busy_o   = (state_q == TRIG_WAIT);

    // Staging registers: always writable, never observed by the datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_div_q <= DIV_W'(RST_DIV);
            stg_sel_q <= SEL_W'(RST_SEL);
        end else begin
            if (div_wr_i) stg_div_q <= div_wdata_i;
            if (sel_wr_i) stg_sel_q <= sel_wdata_i;
        end
    end

    // Working registers and trigger state
    always_ff @(posedge clk) begin
        if (rst) begin
            act_div_o <= DIV_W'(RST_DIV);
            act_sel_o <= SEL_W'(RST_SEL);
            state_q   <= TRIG_IDLE;
        end else if (commit_o) begin
            act_div_o <= stg_div_q;
            act_sel_o <= stg_sel_q;
            state_q   <= TRIG_IDLE;
        end else if (trig_set_i) begin
            state_q   <= TRIG_WAIT;
        end
    end

endmodule

// File: rtl/frac_div_src_pick.sv
module frac_div_src_pick #(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               en_o,
    output logic               valid_o
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = (sel_i == SEL_W'(g));
    end

    assign valid_o = |hit;
    assign en_o    = |(hit & src_en_i);

endmodule

// File: rtl/frac_div_accum.sv
module frac_div_accum #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned FRAC_W = 3,
    parameter int unsigned ACC_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             wrap_o,
    output logic             pulse_o,
    output logic [ACC_W-1:0] acc_o,
    output logic [ACC_W-1:0] div_scaled_o
);

    localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    assign div_scaled_o = ACC_W'(div_i) + STEP;
    assign sum          = acc_q + STEP;
    assign wrap_o       = en_i && (sum >= div_scaled_o);
    assign acc_o        = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= wrap_o;
            if (restart_i)   acc_q <= '0;
            else if (wrap_o) acc_q <= sum - div_scaled_o;
            else if (en_i)   acc_q <= sum;
        end
    end

endmodule

// File: rtl/frac_clk_divider.sv
module frac_clk_divider
    import frac_div_pkg::*;
#(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned FRAC_W  = 3,
    parameter int unsigned RST_DIV = 0,
    parameter int unsigned RST_SEL = 0,
    localparam int unsigned SEL_W  = sel_width(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               div_wr_i,
    input  logic [DIV_W-1:0]   div_wdata_i,
    input  logic               sel_wr_i,
    input  logic [SEL_W-1:0]   sel_wdata_i,
    input  logic               trig_set_i,
    output logic               trig_busy_o,
    output logic               div_pulse_o
);

    localparam int unsigned ACC_W = acc_width(DIV_W, FRAC_W);

    logic [DIV_W-1:0] act_div;
    logic [SEL_W-1:0] act_sel;
    logic             en_sel;
    logic             sel_valid;
    logic             wrap;
    logic             commit;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] div_scaled;

    frac_div_cfg #(
        .DIV_W(DIV_W), .SEL_W(SEL_W), .RST_DIV(RST_DIV), .RST_SEL(RST_SEL)
    ) i_cfg (
        .clk        (clk),
        .rst        (rst),
        .div_wr_i   (div_wr_i),
        .div_wdata_i(div_wdata_i),
        .sel_wr_i   (sel_wr_i),
        .sel_wdata_i(sel_wdata_i),
        .trig_set_i (trig_set_i),
        .boundary_i (wrap || !sel_valid),
        .act_div_o  (act_div),
        .act_sel_o  (act_sel),
        .busy_o     (trig_busy_o),
        .commit_o   (commit)
    );

    frac_div_src_pick #(
        .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)
    ) i_pick (
        .src_en_i(src_en_i),
        .sel_i   (act_sel),
        .en_o    (en_sel),
        .valid_o (sel_valid)
    );

    frac_div_accum #(
        .DIV_W(DIV_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)
    ) i_accum (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_sel),
        .restart_i   (commit),
        .div_i       (act_div),
        .wrap_o      (wrap),
        .pulse_o     (div_pulse_o),
        .acc_o       (acc_q),
        .div_scaled_o(div_scaled)
    );

endmodule

// File: rtl/frac_clk_divider_chk.sv
module frac_clk_divider_chk #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned SEL_W = 2,
    parameter int unsigned ACC_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             trig_set_i,
    input logic             busy,
    input logic             pulse,
    input logic             en_sel,
    input logic             sel_valid,
    input logic [DIV_W-1:0] act_div,
    input logic [SEL_W-1:0] act_sel,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] div_scaled
);

    assert_acc_bound_R2: assert property (@(posedge clk) disable iff (rst)
        acc < div_scaled);

    assert_pulse_after_enable_R3: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(en_sel));

    assert_hold_active_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(act_div) && $stable(act_sel)));

    assert_busy_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(trig_set_i));

    assert_commit_edge_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (pulse || !$past(sel_valid)));

    assert_idle_invalid_R7: assert property (@(posedge clk) disable iff (rst)
        !sel_valid |=> !pulse);

endmodule

bind frac_clk_divider frac_clk_divider_chk #(
    .DIV_W(DIV_W), .SEL_W(SEL_W), .ACC_W(ACC_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .trig_set_i(trig_set_i),
    .busy      (trig_busy_o),
    .pulse     (div_pulse_o),
    .en_sel    (en_sel),
    .sel_valid (sel_valid),
    .act_div   (act_div),
    .act_sel   (act_sel),
    .acc       (acc_q),
    .div_scaled(div_scaled)
);

// File: tb/test_frac_clk_divider.sv
module test_frac_clk_divider;

    localparam int NSRC = 3;
    localparam int STEP = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] src_en_i = '0;
    logic       div_wr_i = 1'b0;
    logic [7:0] div_wdata_i = '0;
    logic       sel_wr_i = 1'b0;
    logic [1:0] sel_wdata_i = '0;
    logic       trig_set_i = 1'b0;
    logic       trig_busy_o;
    logic       div_pulse_o;

    int checks = 0;
    int fails = 0;
    int pulse_cnt = 0;
    bit finished = 1'b0;

    // requirement-level model state
    int m_div = 0, m_sel = 0, st_div = 0, st_sel = 0, m_acc = 0;
    bit m_busy = 1'b0, exp_pulse = 1'b0, exp_busy = 1'b0;

    always #10 clk = ~clk;

    frac_clk_divider i_frac_clk_divider (
        .clk(clk), .rst(rst), .src_en_i(src_en_i),
        .div_wr_i(div_wr_i), .div_wdata_i(div_wdata_i),
        .sel_wr_i(sel_wr_i), .sel_wdata_i(sel_wdata_i),
        .trig_set_i(trig_set_i), .trig_busy_o(trig_busy_o),
        .div_pulse_o(div_pulse_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pulses_for(input int n, input int field);
        return (n * STEP) / (field + STEP);
    endfunction

    task automatic observe();
        @(negedge clk);
        chk(div_pulse_o == exp_pulse, "R3 pulse timing", int'(div_pulse_o), int'(exp_pulse));
        chk(trig_busy_o == exp_busy, "R5 busy readback", int'(trig_busy_o), int'(exp_busy));
        if (div_pulse_o) pulse_cnt++;
    endtask

    task automatic apply(input logic [2:0] en, input bit wd, input int dv,
                         input bit ws, input int sv, input bit tr);
        bit valid, e, wrap, commit;
        int sum, d;
        src_en_i    = en;
        div_wr_i    = wd;
        div_wdata_i = 8'(dv);
        sel_wr_i    = ws;
        sel_wdata_i = 2'(sv);
        trig_set_i  = tr;
        valid  = (m_sel < NSRC);
        e      = valid && en[m_sel];
        sum    = m_acc + STEP;
        d      = m_div + STEP;
        wrap   = e && (sum >= d);
        commit = m_busy && (wrap || !valid);
        exp_pulse = wrap;
        if (commit) m_acc = 0;
        else if (wrap) m_acc = sum - d;
        else if (e) m_acc = sum;
        if (commit) begin
            m_div = st_div;
            m_sel = st_sel;
        end
        if (wd) st_div = dv;
        if (ws) st_sel = sv;
        m_busy   = commit ? 1'b0 : (m_busy | tr);
        exp_busy = m_busy;
    endtask

    task automatic cyc(input logic [2:0] en);
        observe();
        apply(en, 0, 0, 0, 0, 0);
    endtask

    // count pulses over n enables with the given mask, then one idle cycle
    task automatic window(input int n, input logic [2:0] mask, input int exp, input string tag);
        cyc(3'b000);
        pulse_cnt = 0;
        for (int i = 0; i < n; i++) cyc(mask);
        cyc(3'b000);
        chk(pulse_cnt == exp, tag, pulse_cnt, exp);
    endtask

    // stage divisor and selector, trigger, wait for the update to land
    task automatic prog(input int dv, input int sv, output int waited);
        bit old_valid;
        observe();
        apply(3'b000, 1, dv, 1, sv, 0);
        observe();
        apply(3'b000, 0, 0, 0, 0, 1);
        old_valid = (m_sel < NSRC);
        waited = 0;
        for (int i = 0; i < 700; i++) begin
            observe();
            if (i == 0) chk(trig_busy_o == 1'b1, "R5 busy after trigger", int'(trig_busy_o), 1);
            if (!trig_busy_o) break;
            waited++;
            apply(3'b111, 0, 0, 0, 0, 0);
        end
        if (old_valid)
            chk(div_pulse_o == 1'b1, "R6 busy falls with pulse", int'(div_pulse_o), 1);
        chk(trig_busy_o == 1'b0, "R6 update completes", int'(trig_busy_o), 0);
        apply(3'b000, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int w;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(trig_busy_o == 1'b0, "R1 reset busy", int'(trig_busy_o), 0);
        chk(div_pulse_o == 1'b0, "R1 reset pulse", int'(div_pulse_o), 0);
        apply(3'b000, 0, 0, 0, 0, 0);

        // R1: reset ratio 1.0 on source 0
        window(10, 3'b001, 10, "R1 divide by one");

        // R2: fractional ratios
        prog(4, 0, w);
        window(24, 3'b001, pulses_for(24, 4), "R2 ratio 1.5");
        prog(5, 0, w);
        window(26, 3'b001, pulses_for(26, 5), "R2 ratio 1.625");

        // R4: staged write without trigger leaves the ratio alone
        prog(4, 0, w);
        cyc(3'b000);
        pulse_cnt = 0;
        observe();
        apply(3'b001, 1, 20, 1, 2, 0);
        for (int i = 1; i < 24; i++) cyc(3'b001);
        cyc(3'b000);
        chk(pulse_cnt == 16, "R4 staged values inert", pulse_cnt, 16);
        // R4: the last staged value wins
        observe();
        apply(3'b000, 1, 12, 1, 0, 0);
        prog(2, 0, w);
        window(30, 3'b001, pulses_for(30, 2), "R4 last staged value applied");

        // R9: largest field
        prog(255, 0, w);
        window(263, 3'b001, 8, "R9 max divisor");

        // R8: only the selected stream counts
        prog(5, 1, w);
        window(40, 3'b101, 0, "R8 unselected ignored");
        window(26, 3'b010, pulses_for(26, 5), "R8 selected counted");

        // R7: invalid selector silences output; update from it is immediate
        prog(5, 3, w);
        window(30, 3'b111, 0, "R7 invalid selector idle");
        prog(0, 0, w);
        chk(w == 1, "R7 immediate commit", w, 1);
        window(5, 3'b001, 5, "R7 recovered divide by one");

        // R5: second trigger while pending is ignored (model-checked each cycle)
        prog(6, 0, w);
        observe();
        apply(3'b000, 1, 1, 0, 0, 1);
        observe();
        apply(3'b001, 0, 0, 0, 0, 1);
        for (int i = 0; i < 40; i++) cyc(3'b001);

        // random phase, checked cycle by cycle against the model (R2 R3 R5 R6)
        for (int i = 0; i < 4000; i++) begin
            observe();
            apply(3'($urandom % 8),
                  ($urandom % 16) == 0, int'($urandom % 256),
                  ($urandom % 16) == 0, int'($urandom % 4),
                  ($urandom % 8) == 0);
        end
        cyc(3'b000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule